// File: doc/BRIEF.md
# Bus Wait-State Generator

This block stretches a processor bus cycle so that a slow peripheral has time to respond. It walks the bus through its phases: an address phase (T1), a command phase (T2), a data-wait phase (T3), any number of inserted wait states (TW), and a final data-capture phase (T4). A bus cycle is lengthened by repeating the wait phase. The number of repeats comes from a wait count programmed for each chip-select region. An external READY line can lengthen the cycle further.

Each region has its own wait count and two configuration bits. The first bit says whether the external READY line is honoured at all. The second bit says how the line is read. In normally-ready mode, the level of the line at each wait-phase edge decides whether the cycle goes on. In normally-not-ready mode, the block waits for the peripheral to assert the line, and it remembers that assertion. The region's settings are captured when a cycle starts. At the start of T4 the block gives a one-cycle data-latch strobe. All pins are plain control and status pins: no data flows through the block, so there is no valid/ready interface and no back-pressure.

Top module: `ws_gen`

## Requirements
- R1: While `rst_n` is low, and at the first sample after its release, `bus_state` is 0 (idle) and `extend`, `latch_stb` and `busy` are all low. A reset in the middle of a cycle returns the block to idle.
- R2: `bus_state` uses this encoding: 0 idle, 1 T1, 2 T2, 3 T3, 4 wait state, 5 T4. A `cyc_start` that is high at a clock edge while the state is idle or T4 moves the state to T1 at that edge. Each following edge moves it to T2 and then to T3.
- R3: The region is chosen by `cs_idx`. Its wait count is bits [i*WAIT_W +: WAIT_W] of `wait_cfg`. The count and both of the region's configuration bits are captured at the edge that starts the cycle; changes after that edge do not affect the cycle. With READY not in use, a count of N gives exactly N wait states between T3 and T4.
- R4: `extend` is high in every wait-state cycle and in no other cycle. A wait state is always followed by another wait state or by T4.
- R5: `latch_stb` is high for exactly one cycle, the T4 cycle. After T4 the state returns to idle, unless a new cycle starts at that edge.
- R6: When the region's `rdy_use` bit is 0, `ready_in` has no effect on the length of the cycle.
- R7: When `rdy_use`=1 and `rdy_nnr`=0 (normally-ready), the cycle leaves T3 or a wait state at an edge only if the programmed count has run out and `ready_in` is high at that edge. While `ready_in` is low, the cycle is lengthened.
- R8: When `rdy_use`=1 and `rdy_nnr`=1 (normally-not-ready), a high `ready_in` sampled at any edge from T1 onward is held until the cycle ends. The cycle then leaves as soon as the count has run out, even if `ready_in` has since gone low.
- R9: A `cyc_start` that arrives while the state is T1, T2, T3 or a wait state is ignored.
- R10: `busy` is high from T1 through T4 and low when idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock; all state changes on the rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cyc_start | input | 1 | Cycle-start request, sampled on the rising edge |
| cs_idx | input | CS_W | Chip-select region of the new cycle |
| wait_cfg | input | NUM_CS*WAIT_W | Packed wait count of each region |
| rdy_use | input | NUM_CS | Per region: honour `ready_in` |
| rdy_nnr | input | NUM_CS | Per region: 1 normally-not-ready, 0 normally-ready |
| ready_in | input | 1 | External READY from the peripheral |
| bus_state | output | 3 | Current bus phase, encoded as in R2 |
| extend | output | 1 | High during inserted wait states |
| latch_stb | output | 1 | Data-latch strobe, high in T4 |
| busy | output | 1 | High while a cycle is in progress |

## Verification
If `cyc_start` is accepted at rising edge k, T1 is visible after edge k. T2 is visible after edge k+1 and T3 after edge k+2. T4 is visible after edge k+3+W, where W is the number of wait states. The bench computes W from the count, the region bits and the READY pattern it drives. It samples every output at the falling edge that follows each rising edge, so each check sees the registered state of exactly one bus phase. At that same falling edge it drives the READY level that the next rising edge will sample. The bench records the phase index at which T4 first appears and compares it with the predicted index. It also compares the number of cycles with `extend` high against W, and checks that the phase after T4 is idle.

// File: rtl/ws_pkg.sv
package ws_pkg;
  typedef enum logic [2:0] {
    PH_IDLE = 3'd0,
    PH_T1   = 3'd1,
    PH_T2   = 3'd2,
    PH_T3   = 3'd3,
    PH_TW   = 3'd4,
    PH_T4   = 3'd5
  } bus_ph_e;
endpackage

// File: rtl/ws_cfg_mux.sv
module ws_cfg_mux #(
  parameter int NUM_CS = 4,
  parameter int WAIT_W = 4,
  localparam int CS_W = (NUM_CS > 1) ? $clog2(NUM_CS) : 1
) (
  input  logic [CS_W-1:0]          sel,
  input  logic [NUM_CS*WAIT_W-1:0] cnt_all,
  input  logic [NUM_CS-1:0]        use_all,
  input  logic [NUM_CS-1:0]        nnr_all,
  output logic [WAIT_W-1:0]        cnt_sel,
  output logic                     use_sel,
  output logic                     nnr_sel
);
  logic [WAIT_W-1:0] cnt_arr [NUM_CS];

  for (genvar g = 0; g < NUM_CS; g++) begin : g_unpack
    assign cnt_arr[g] = cnt_all[g*WAIT_W +: WAIT_W];
  end

  always_comb begin
    cnt_sel = '0;
    use_sel = 1'b0;
    nnr_sel = 1'b0;
    for (int i = 0; i < NUM_CS; i++) begin
      if (sel == CS_W'(i)) begin
        cnt_sel = cnt_arr[i];
        use_sel = use_all[i];
        nnr_sel = nnr_all[i];
      end
    end
  end
endmodule

// File: rtl/ws_wait_ctr.sv
module ws_wait_ctr #(
  parameter int WAIT_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [WAIT_W-1:0] load_val,
  input  logic              dec,
  output logic              expired
);
  logic [WAIT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)          cnt_q <= '0;
    else if (load)       cnt_q <= load_val;
    else if (dec && cnt_q != '0) cnt_q <= cnt_q - 1'b1;
  end

  assign expired = (cnt_q == '0);
endmodule

// File: rtl/ws_ready_qual.sv
module ws_ready_qual (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic use_in,
  input  logic nnr_in,
  input  logic track,
  input  logic ready_in,
  output logic ready_ok
);
  logic use_q, nnr_q, seen_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      use_q  <= 1'b0;
      nnr_q  <= 1'b0;
      seen_q <= 1'b0;
    end else if (load) begin
      use_q  <= use_in;
      nnr_q  <= nnr_in;
      seen_q <= 1'b0;
    end else if (track) begin
      seen_q <= seen_q | ready_in;
    end
  end

  assign ready_ok = !use_q || ready_in || (nnr_q && seen_q);
endmodule

// File: rtl/ws_gen.sv
module ws_gen
  import ws_pkg::*;
#(
  parameter int NUM_CS = 4,
  parameter int WAIT_W = 4,
  localparam int CS_W = (NUM_CS > 1) ? $clog2(NUM_CS) : 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cyc_start,
  input  logic [CS_W-1:0]          cs_idx,
  input  logic [NUM_CS*WAIT_W-1:0] wait_cfg,
  input  logic [NUM_CS-1:0]        rdy_use,
  input  logic [NUM_CS-1:0]        rdy_nnr,
  input  logic                     ready_in,
  output logic [2:0]               bus_state,
  output logic                     extend,
  output logic                     latch_stb,
  output logic                     busy
);
  bus_ph_e           ph_q, ph_d;
  logic              start_ok, in_wait, cnt_done, rdy_ok;
  logic [WAIT_W-1:0] sel_cnt;
  logic              sel_use, sel_nnr;

  assign start_ok = cyc_start && (ph_q == PH_IDLE || ph_q == PH_T4);
  assign in_wait  = (ph_q == PH_T3) || (ph_q == PH_TW);

  ws_cfg_mux #(.NUM_CS(NUM_CS), .WAIT_W(WAIT_W)) u_mux (
    .sel     (cs_idx),
    .cnt_all (wait_cfg),
    .use_all (rdy_use),
    .nnr_all (rdy_nnr),
    .cnt_sel (sel_cnt),
    .use_sel (sel_use),
    .nnr_sel (sel_nnr)
  );

  ws_wait_ctr #(.WAIT_W(WAIT_W)) u_ctr (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (start_ok),
    .load_val (sel_cnt),
    .dec      (in_wait),
    .expired  (cnt_done)
  );

  ws_ready_qual u_rdy (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (start_ok),
    .use_in   (sel_use),
    .nnr_in   (sel_nnr),
    .track    (busy && ph_q != PH_T4),
    .ready_in (ready_in),
    .ready_ok (rdy_ok)
  );

  always_comb begin
    ph_d = ph_q;
    unique case (ph_q)
      PH_IDLE: if (start_ok) ph_d = PH_T1;
      PH_T1:   ph_d = PH_T2;
      PH_T2:   ph_d = PH_T3;
      PH_T3,
      PH_TW:   ph_d = (cnt_done && rdy_ok) ? PH_T4 : PH_TW;
      PH_T4:   ph_d = start_ok ? PH_T1 : PH_IDLE;
      default: ph_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) ph_q <= PH_IDLE;
    else        ph_q <= ph_d;
  end

  assign bus_state = ph_q;
  assign extend    = (ph_q == PH_TW);
  assign latch_stb = (ph_q == PH_T4);
  assign busy      = (ph_q != PH_IDLE);
endmodule

// File: rtl/ws_gen_chk.sv
module ws_gen_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cyc_start,
  input logic [2:0] bus_state,
  input logic       extend,
  input logic       latch_stb,
  input logic       busy
);
  p_start_to_t1_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_start && (bus_state == 3'd0 || bus_state == 3'd5)) |=> (bus_state == 3'd1));

  p_t1_to_t2_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_state == 3'd1) |=> (bus_state == 3'd2));

  p_t2_to_t3_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_state == 3'd2) |=> (bus_state == 3'd3));

  p_wait_exit_r4: assert property (@(posedge clk) disable iff (!rst_n)
    extend |=> (extend || latch_stb));

  p_latch_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    latch_stb |=> !latch_stb);

  p_t4_origin_r3: assert property (@(posedge clk) disable iff (!rst_n)
    latch_stb |-> ($past(bus_state) == 3'd3 || $past(bus_state) == 3'd4));

  p_start_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !latch_stb) |=> (bus_state != 3'd1));

  p_after_t4_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (latch_stb && !cyc_start) |=> !busy);
endmodule

bind ws_gen ws_gen_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cyc_start (cyc_start),
  .bus_state (bus_state),
  .extend    (extend),
  .latch_stb (latch_stb),
  .busy      (busy)
);

// File: tb/test_ws_gen.sv
module test_ws_gen;
  localparam int NUM_CS = 4;
  localparam int WAIT_W = 4;
  localparam int CS_W   = 2;
  localparam int LIMIT  = 40;

  logic                     clk = 1'b0;
  logic                     rst_n = 1'b0;
  logic                     cyc_start = 1'b0;
  logic [CS_W-1:0]          cs_idx = '0;
  logic [NUM_CS*WAIT_W-1:0] wait_cfg = '0;
  logic [NUM_CS-1:0]        rdy_use = '0;
  logic [NUM_CS-1:0]        rdy_nnr = '0;
  logic                     ready_in = 1'b0;
  logic [2:0]               bus_state;
  logic                     extend, latch_stb, busy;

  int n_chk = 0;
  int n_bad = 0;
  int cycles = 0;

  always #10 clk = ~clk;

  ws_gen #(.NUM_CS(NUM_CS), .WAIT_W(WAIT_W)) i_ws_gen (
    .clk(clk), .rst_n(rst_n), .cyc_start(cyc_start), .cs_idx(cs_idx),
    .wait_cfg(wait_cfg), .rdy_use(rdy_use), .rdy_nnr(rdy_nnr),
    .ready_in(ready_in), .bus_state(bus_state), .extend(extend),
    .latch_stb(latch_stb), .busy(busy)
  );

  // Packing: cs[13:12] count[11:8] use[7] nnr[6] base[5] pulse[4:0] (31 = none)
  localparam logic [13:0] VEC [0:8] = '{
    {2'd0, 4'd0,  1'b0, 1'b0, 1'b0, 5'd31},
    {2'd1, 4'd3,  1'b0, 1'b0, 1'b0, 5'd31},
    {2'd2, 4'd0,  1'b1, 1'b0, 1'b1, 5'd31},
    {2'd3, 4'd1,  1'b1, 1'b0, 1'b1, 5'd3},
    {2'd0, 4'd0,  1'b1, 1'b1, 1'b0, 5'd1},
    {2'd1, 4'd0,  1'b1, 1'b1, 1'b0, 5'd4},
    {2'd2, 4'd1,  1'b1, 1'b0, 1'b0, 5'd5},
    {2'd3, 4'd2,  1'b0, 1'b0, 1'b0, 5'd31},
    {2'd1, 4'd15, 1'b0, 1'b0, 1'b0, 5'd31}
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic bit rdy_at(input bit base, input int pulse, input int i);
    return base ^ (i == pulse);
  endfunction

  // Reference: index (T1 = 0) at which T4 is visible
  function automatic int model_t4(input int n, input bit use_r, input bit nnr,
                                  input bit base, input int pulse);
    bit seen = 0;
    for (int i = 0; i < LIMIT; i++) begin
      bit r = rdy_at(base, pulse, i);
      if (i >= 2) begin
        bit ok = !use_r || r || (nnr && seen);
        if (i - 2 >= n && ok) return i + 1;
      end
      seen = seen | r;
    end
    return -1;
  endfunction

  task automatic set_region(input int cs, input int n, input bit use_r, input bit nnr);
    for (int k = 0; k < NUM_CS; k++) begin
      wait_cfg[k*WAIT_W +: WAIT_W] = (k == cs) ? WAIT_W'(n) : WAIT_W'(7);
      rdy_use[k] = (k == cs) ? use_r : ~use_r;
      rdy_nnr[k] = (k == cs) ? nnr : ~nnr;
    end
    cs_idx = CS_W'(cs);
  endtask

  // Runs one cycle; caller is at a negedge. Options: mid-cycle cfg change, stray start.
  task automatic run_cycle(input int cs, input int n, input bit use_r, input bit nnr,
                           input bit base, input int pulse, input bit disturb,
                           input string req);
    int exp_t4, got_t4, tw;
    exp_t4 = model_t4(n, use_r, nnr, base, pulse);
    set_region(cs, n, use_r, nnr);
    cyc_start = 1'b1;
    ready_in = 1'b0;
    got_t4 = -1;
    tw = 0;
    for (int i = 0; i < LIMIT; i++) begin
      @(negedge clk);
      cyc_start = 1'b0;
      if (i == 0) begin
        check(bus_state == 3'd1 && busy, {req, " T1 after start (R2,R10)"}, bus_state, 1);
        if (disturb) begin
          wait_cfg = '1;
          rdy_use = ~rdy_use;
          rdy_nnr = ~rdy_nnr;
        end
      end
      if (i == 1) begin
        check(bus_state == 3'd2, {req, " T2 (R2)"}, bus_state, 2);
        if (disturb) cyc_start = 1'b1;
      end
      if (extend) tw++;
      if (bus_state == 3'd5) begin
        got_t4 = i;
        check(latch_stb == 1'b1, {req, " strobe in T4 (R5)"}, latch_stb, 1);
        ready_in = 1'b0;
        break;
      end
      ready_in = rdy_at(base, pulse, i);
    end
    check(got_t4 == exp_t4, {req, " T4 index"}, got_t4, exp_t4);
    check(tw == exp_t4 - 3, {req, " wait-state count on extend (R4)"}, tw, exp_t4 - 3);
    @(negedge clk);
    check(bus_state == 3'd0 && !latch_stb && !busy, {req, " idle after T4 (R5,R10)"},
          bus_state, 0);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual %0d expected %0d", cycles, 100000);
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(bus_state == 3'd0 && !extend && !latch_stb && !busy, "R1 reset state",
          bus_state, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(bus_state == 3'd0 && !busy, "R1 after release", bus_state, 0);

    for (int v = 0; v < 9; v++) begin
      logic [13:0] e = VEC[v];
      string tag;
      if (e[7] == 1'b0)      tag = "R3 R6 vec";
      else if (e[6] == 1'b0) tag = "R7 vec";
      else                   tag = "R8 vec";
      run_cycle(int'(e[13:12]), int'(e[11:8]), e[7], e[6], e[5], int'(e[4:0]), 1'b0, tag);
    end

    // R6: READY toggling with READY unused has no effect
    run_cycle(2, 1, 1'b0, 1'b0, 1'b1, 3, 1'b0, "R6 ready ignored");
    // R3 + R9: config change and stray start after the cycle begins
    run_cycle(1, 2, 1'b0, 1'b0, 1'b0, 31, 1'b1, "R3 R9 latched cfg");

    // R5: back-to-back, start during T4 goes straight to T1
    set_region(0, 0, 1'b0, 1'b0);
    cyc_start = 1'b1;
    @(negedge clk); cyc_start = 1'b0;
    @(negedge clk);
    @(negedge clk);
    @(negedge clk);
    check(bus_state == 3'd5, "R5 T4 reached", bus_state, 5);
    cyc_start = 1'b1;
    @(negedge clk); cyc_start = 1'b0;
    check(bus_state == 3'd1, "R2 R5 back-to-back T1", bus_state, 1);
    repeat (4) @(negedge clk);
    check(bus_state == 3'd0, "R5 idle after second cycle", bus_state, 0);

    // R1: reset mid-cycle
    set_region(3, 9, 1'b0, 1'b0);
    cyc_start = 1'b1;
    @(negedge clk); cyc_start = 1'b0;
    repeat (4) @(negedge clk);
    check(extend == 1'b1, "R4 in wait before reset", extend, 1);
    rst_n = 1'b0;
    @(negedge clk);
    check(bus_state == 3'd0 && !extend && !busy, "R1 reset mid-cycle", bus_state, 0);
    rst_n = 1'b1;
    @(negedge clk);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule